// File: doc/BRIEF.md
# Two-Bit Decoded PLA Plane

This block is a programmable sum-of-products array whose binary inputs are grouped in pairs. Each pair goes through a small decoder before it reaches the AND plane. The pair forms a four-valued variable. The decoder turns that variable into four lines, and each line is false for exactly one of the four values. Any product column can AND any subset of these lines, across all pairs. A single column can therefore realise any set of values of one pair, for example the equivalence of its two bits. Each output ORs the columns selected by its row mask.

The masks are loaded one word per clock through a write port. Reset clears every mask. The logic path from the inputs to the outputs is purely combinational, so a new mask takes effect on the clock edge that stores it. No flow control applies: data enters as level inputs and leaves as level outputs, and there is no valid/ready handshake or back-pressure.

Top module: `decoded_pla`

## Requirements
- R1: Pair p is built from `in_bits[2p+1]` (the high bit a) and `in_bits[2p]` (the low bit b), giving the value X = 2a + b. So ab = 00, 01, 10, 11 gives X = 0, 1, 2, 3.
- R2: Decoder line j (j = 0..3) of a pair is 1 exactly when X differs from j, so exactly three of its four lines are 1. Line 0 is a+b, line 1 is a+b', line 2 is a'+b and line 3 is a'+b'.
- R3: Column c is the AND of the lines whose bit is set in its column mask. Bit 4p+j of the mask selects line j of pair p.
- R4: A column whose mask is all zero evaluates to 1.
- R5: Output k is the OR of the columns whose bit c is set in row mask k. An all-zero row mask gives 0.
- R6: When `prog_we` is high at a rising edge, the mask selected by `prog_addr` is loaded from `prog_data`. Address c < NCOL loads column mask c from bits [4*NPAIR-1:0]. Address NCOL+k loads row mask k from bits [NCOL-1:0]. The outputs follow the new mask from that edge onward, with no further delay.
- R7: A write to an address at or above NCOL+NOUT changes no mask and no output.
- R8: While `rst_n` is low, every mask is cleared, so every output is 0.
- R9: Selecting lines 1 and 2 of one pair in a single column gives the equivalence of that pair's two bits, which is true for X in {0,3}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask store |
| rst_n | input | 1 | Active-low synchronous reset; clears all masks |
| prog_we | input | 1 | Mask write enable |
| prog_addr | input | 4 | Mask address: columns first, then rows |
| prog_data | input | 8 | Mask word to be written |
| in_bits | input | 4 | Binary inputs, two per four-valued variable |
| out_bits | output | 2 | Sum-of-products outputs |

## Verification
A mask write and a change on the data inputs can fall in the same cycle. The bench drives a new input pattern and a write to a row mask together on a falling edge. It checks that, before the next rising edge, the output matches the old mask applied to the new inputs. After that edge it must match the new mask applied to the same inputs. A write to an unmapped address is also issued while the inputs stay fixed, and the bench confirms that the outputs stay unchanged.

// File: rtl/decoded_pla_pkg.sv
package decoded_pla_pkg;
  localparam int LINES_PER_PAIR = 4;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pla_pair_decoder.sv
module pla_pair_decoder (
  input  logic [1:0] pair_in,
  output logic [3:0] lines
);
  always_comb begin
    for (int j = 0; j < 4; j++) begin
      lines[j] = (pair_in != 2'(j));
    end
  end

  // p_one_cold_r2: exactly one line of a pair is low
  always_comb begin
    p_one_cold_r2: assert ($countones(lines) == 3);
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int NLINE = 8,
  parameter int NCOL  = 8
) (
  input  logic [NLINE-1:0]           lines,
  input  logic [NCOL-1:0][NLINE-1:0] col_mask,
  output logic [NCOL-1:0]            col_out
);
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign col_out[c] = &(lines | ~col_mask[c]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NCOL = 8,
  parameter int NOUT = 2
) (
  input  logic [NCOL-1:0]           col_in,
  input  logic [NOUT-1:0][NCOL-1:0] row_mask,
  output logic [NOUT-1:0]           row_out
);
  for (genvar k = 0; k < NOUT; k++) begin : g_row
    assign row_out[k] = |(col_in & row_mask[k]);
  end

  // p_out_needs_col_r5: a high output needs at least one high column
  always_comb begin
    p_out_needs_col_r5: assert (!(|row_out) || (|col_in));
  end
endmodule

// File: rtl/decoded_pla.sv
module decoded_pla
  import decoded_pla_pkg::*;
#(
  parameter int NPAIR  = 2,
  parameter int NCOL   = 8,
  parameter int NOUT   = 2,
  parameter int NLINE  = NPAIR * LINES_PER_PAIR,
  parameter int ADDR_W = $clog2(NCOL + NOUT),
  parameter int DATA_W = imax(NLINE, NCOL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [2*NPAIR-1:0] in_bits,
  output logic [NOUT-1:0]   out_bits
);
  localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(NCOL + NOUT);

  logic [NCOL-1:0][NLINE-1:0] col_mask;
  logic [NOUT-1:0][NCOL-1:0]  row_mask;
  logic [NLINE-1:0]           lines;
  logic [NCOL-1:0]            col_out;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pla_pair_decoder u_dec (
      .pair_in (in_bits[2*p +: 2]),
      .lines   (lines[LINES_PER_PAIR*p +: LINES_PER_PAIR])
    );
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_cmask
    always_ff @(posedge clk) begin
      if (!rst_n) col_mask[c] <= '0;
      else if (prog_we && prog_addr == ADDR_W'(c)) col_mask[c] <= prog_data[NLINE-1:0];
    end

    p_col_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_we && prog_addr == ADDR_W'(c)) |=> col_mask[c] == $past(prog_data[NLINE-1:0]));
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_rmask
    always_ff @(posedge clk) begin
      if (!rst_n) row_mask[k] <= '0;
      else if (prog_we && prog_addr == ADDR_W'(NCOL + k)) row_mask[k] <= prog_data[NCOL-1:0];
    end
  end

  pla_and_plane #(.NLINE(NLINE), .NCOL(NCOL)) u_and (
    .lines    (lines),
    .col_mask (col_mask),
    .col_out  (col_out)
  );

  pla_or_plane #(.NCOL(NCOL), .NOUT(NOUT)) u_or (
    .col_in   (col_out),
    .row_mask (row_mask),
    .row_out  (out_bits)
  );

  p_bad_addr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && prog_addr >= ADDR_END) |=> ($stable(col_mask) && $stable(row_mask)));

  p_reset_clears_r8: assert property (@(posedge clk)
    !rst_n |=> (out_bits == '0));
endmodule

// File: tb/tb_decoded_pla.sv
module tb_decoded_pla;
  logic       clk = 0;
  logic       rst_n;
  logic       prog_we;
  logic [3:0] prog_addr;
  logic [7:0] prog_data;
  logic [3:0] in_bits;
  logic [1:0] out_bits;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  decoded_pla dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .in_bits(in_bits), .out_bits(out_bits)
  );

  // expected {out1,out0} for in_bits 0..15 under the main program:
  // out0 = equiv(pair0) | (X1==3), out1 = (X0!=0) & (X1!=1)
  localparam logic [1:0] EXP [16] = '{
    2'b01, 2'b10, 2'b10, 2'b11,
    2'b01, 2'b00, 2'b00, 2'b01,
    2'b01, 2'b10, 2'b10, 2'b11,
    2'b01, 2'b11, 2'b11, 2'b11
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_we = 1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_we = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: out=%b expected=done", out_bits);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; prog_we = 0; prog_addr = 0; prog_data = 0; in_bits = 0;
    repeat (3) @(negedge clk);
    // R8: cleared masks give zero outputs
    for (int i = 0; i < 16; i += 5) begin
      in_bits = 4'(i); #1;
      check("R8 reset", out_bits, 2'b00);
    end
    rst_n = 1;

    // R1 R2: single-line column routed to out0, sweep pair0
    for (int j = 0; j < 4; j++) begin
      wr(4'd3, 8'(1 << j));
      wr(4'd8, 8'h08);
      for (int x = 0; x < 4; x++) begin
        @(negedge clk); in_bits = 4'(x); #1;
        check("R2 line", {1'b0, out_bits[0]}, {1'b0, 1'(x != j)});
      end
    end
    // R1: pair1 decoded from bits 3:2 (line 0 of pair1 = bit 4)
    wr(4'd3, 8'h10);
    @(negedge clk); in_bits = 4'b0011; #1;
    check("R1 pair1 X=0", {1'b0, out_bits[0]}, 2'b00);
    in_bits = 4'b0100; #1;
    check("R1 pair1 X=1", {1'b0, out_bits[0]}, 2'b01);

    // main program: R3 R5 R9
    wr(4'd0, 8'h06);   // R9 equivalence of pair0
    wr(4'd1, 8'h70);   // X1 == 3
    wr(4'd2, 8'h21);   // X0 != 0 and X1 != 1
    wr(4'd8, 8'h03);
    wr(4'd9, 8'h04);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); in_bits = 4'(i); #1;
      check("R3/R5/R9 table", out_bits, EXP[i]);
    end

    // R7: unmapped address ignored
    in_bits = 4'd5; #1;
    wr(4'd15, 8'hFF);
    wr(4'd10, 8'hFF);
    #1 check("R7 bad addr", out_bits, EXP[5]);

    // R6 with input change in the same cycle; R4 empty column is 1
    @(negedge clk);
    in_bits = 4'd6; prog_we = 1; prog_addr = 4'd9; prog_data = 8'h80;
    #1 check("R6 before edge", out_bits, EXP[6]);
    @(negedge clk); prog_we = 0; #1;
    check("R6/R4 after edge", out_bits, {1'b1, EXP[6][0]});
    for (int i = 0; i < 16; i += 3) begin
      in_bits = 4'(i); #1;
      check("R4 empty column", {1'b0, out_bits[1]}, 2'b01);
    end

    // R5: empty row is 0
    wr(4'd8, 8'h00);
    #1 check("R5 empty row", {1'b0, out_bits[0]}, 2'b00);

    // R8: reset again clears
    @(negedge clk); rst_n = 0;
    @(negedge clk); #1;
    check("R8 re-reset", out_bits, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule